// File: doc/BRIEF.md
# Energy Pulse Output Selector

This block drives three energy pulse pins in a metering datapath. Each pin has its own digital-to-frequency converter. A converter takes one power sum on every sample beat and adds it to a running accumulator. When the accumulator reaches a programmable threshold, the converter fires a pulse and subtracts the threshold. The pulse rate is therefore proportional to the chosen power. Upstream logic forms the per-phase power sums, and that logic is outside this block.

A 16-bit control word is written through a plain write strobe. It sets three things for each pin:
- a 3-bit mode, which chooses the active-power sum or the apparent-power sum, or holds the pin low;
- a disable bit, which blocks only the pin while the converter keeps running;
- a latch-enable bit, which copies the energy register values into a per-pin holding set each time that pin's converter pulses.

Power samples arrive as a valid/ready stream. One beat carries the active and apparent sums for all three pins. `s_ready` is always high, so the block never applies back-pressure. A sample is consumed on every clock edge where `s_valid` is high, and nothing happens on cycles where it is low.

Top module: `epulse_selector`

## Requirements
- R1: After reset, all pins are low and all snapshots are zero. The control word resets to 0x0E00, which means every mode is 000, every disable bit is 1 and every latch-enable bit is 0.
- R2: Mode 000 makes the converter add the active-power sum for its pin on each beat. Pin i's mode sits in control bits [3i+2:3i].
- R3: Mode 010 makes the converter add the apparent-power sum for its pin on each beat.
- R4: Modes 001, 011 and 100 hold the pin low, and the converter's accumulator does not change during those beats.
- R5: Modes 101, 110 and 111 behave exactly like mode 000.
- R6: Control bit 9+i set to 1 holds pin i low while its converter keeps accumulating. Clearing the bit resumes from the existing accumulator state, with no reset.
- R7: When control bit 12+i is 1, the clock edge after each converter pulse for pin i copies `energy_in` into pin i's snapshot. Otherwise the snapshot holds its value.
- R8: Control bit 15 has no effect on any output.
- R9: A control write takes effect for beats accepted after the write edge. A beat accepted on the same edge as a write uses the old mode.
- R10: On a beat, the new sum is acc + value. If the sum is at least `thresh`, the pin pulses high for exactly the following cycle and the accumulator becomes sum − thresh. Otherwise the accumulator becomes sum and no pulse occurs.
- R11: `s_ready` is always 1. With `s_valid` low, accumulators do not change and no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word value |
| thresh | input | 20 | Converter pulse threshold, shared by all pins |
| s_valid | input | 1 | Sample beat valid |
| s_ready | output | 1 | Sample beat ready, always 1 |
| act_sum | input | 48 | Active-power sums, 16 bits per pin, pin 0 in the low bits |
| app_sum | input | 48 | Apparent-power sums, 16 bits per pin |
| energy_in | input | 64 | Two 32-bit energy register values |
| pulse_pin | output | 3 | Energy pulse pins |
| snap_out | output | 192 | Per-pin latched energy snapshots, 64 bits per pin |

## Verification
A wrong accumulator value or a wrong decoded mode shows up as missing, extra or shifted pin pulses. The error becomes visible within one threshold's worth of accumulation. With a threshold of 100 and values up to that size, that is a few beats. A converter that is reset when its pin is re-enabled is caught on the first pulse after the disable bit is cleared. A wrong snapshot trigger changes `snap_out` one cycle after a pulse, which is visible right away because `energy_in` changes on every cycle.

// File: rtl/epulse_pkg.sv
package epulse_pkg;
  localparam int NOUT = 3;
  localparam int CFG_W = 16;
  localparam logic [CFG_W-1:0] CFG_RST = 16'h0E00;
  localparam int DIS_LSB = 9;
  localparam int LAT_LSB = 12;

  typedef enum logic [1:0] {
    SRC_ACT = 2'd0,
    SRC_APP = 2'd1,
    SRC_OFF = 2'd2
  } src_e;

  function automatic src_e decode_mode(input logic [2:0] m);
    case (m)
      3'b010:                 decode_mode = SRC_APP;
      3'b001, 3'b011, 3'b100: decode_mode = SRC_OFF;
      default:                decode_mode = SRC_ACT;
    endcase
  endfunction
endpackage

// File: rtl/epulse_cfg.sv
module epulse_cfg
  import epulse_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output src_e             src   [NOUT],
  output logic [NOUT-1:0]  dis,
  output logic [NOUT-1:0]  lat
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  cfg_q <= CFG_RST;
    else if (we) cfg_q <= wdata;
  end

  genvar i;
  generate
    for (i = 0; i < NOUT; i++) begin : g_dec
      assign src[i] = decode_mode(cfg_q[3*i +: 3]);
      assign dis[i] = cfg_q[DIS_LSB + i];
      assign lat[i] = cfg_q[LAT_LSB + i];
    end
  endgenerate

  // R6
  dis_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> dis == $past(wdata[DIS_LSB +: NOUT]));
endmodule

// File: rtl/epulse_dfc.sv
module epulse_dfc
  import epulse_pkg::*;
#(
  parameter int PW = 16,
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  src_e          src,
  input  logic [PW-1:0] act,
  input  logic [PW-1:0] app,
  input  logic [AW-1:0] thresh,
  output logic          pulse_q
);
  logic [AW-1:0] acc_q;
  logic [AW:0]   sum;
  logic [PW-1:0] val;

  always_comb begin
    val = (src == SRC_APP) ? app : act;
    sum = {1'b0, acc_q} + {{(AW + 1 - PW){1'b0}}, val};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (beat && src != SRC_OFF) begin
        if (sum >= {1'b0, thresh}) begin
          acc_q   <= AW'(sum - {1'b0, thresh});
          pulse_q <= 1'b1;
        end else begin
          acc_q <= sum[AW-1:0];
        end
      end
    end
  end

  // R10
  pulse_needs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(beat));
  // R11
  idle_holds_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(acc_q));
  // R4
  off_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && src == SRC_OFF) |=> (!pulse_q && $stable(acc_q)));
endmodule

// File: rtl/epulse_snap.sv
module epulse_snap #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (take) q <= din;
  end

  // R7
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(q));
endmodule

// File: rtl/epulse_selector.sv
module epulse_selector
  import epulse_pkg::*;
#(
  parameter int PW = 16,
  parameter int AW = 20,
  parameter int EW = 32,
  parameter int NE = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [15:0]            cfg_wdata,
  input  logic [AW-1:0]          thresh,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic [3*PW-1:0]        act_sum,
  input  logic [3*PW-1:0]        app_sum,
  input  logic [NE*EW-1:0]       energy_in,
  output logic [2:0]             pulse_pin,
  output logic [3*NE*EW-1:0]     snap_out
);
  localparam int SW = NE * EW;

  src_e            src [NOUT];
  logic [NOUT-1:0] dis, lat, pulse;
  logic            beat;

  assign s_ready = 1'b1;
  assign beat    = s_valid & s_ready;

  epulse_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .src(src), .dis(dis), .lat(lat)
  );

  genvar i;
  generate
    for (i = 0; i < NOUT; i++) begin : g_out
      epulse_dfc #(.PW(PW), .AW(AW)) u_dfc (
        .clk(clk), .rst_n(rst_n), .beat(beat), .src(src[i]),
        .act(act_sum[i*PW +: PW]), .app(app_sum[i*PW +: PW]),
        .thresh(thresh), .pulse_q(pulse[i])
      );
      epulse_snap #(.W(SW)) u_snap (
        .clk(clk), .rst_n(rst_n), .take(pulse[i] & lat[i]),
        .din(energy_in), .q(snap_out[i*SW +: SW])
      );
      assign pulse_pin[i] = pulse[i] & ~dis[i];
    end
  endgenerate

  // R11
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready);
  // R10
  pin_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse_pin) |-> $past(s_valid));
endmodule

// File: tb/epulse_selector_test.sv
module epulse_selector_test;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic [19:0]   thresh = 20'd100;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [47:0]   act_sum = '0;
  logic [47:0]   app_sum = '0;
  logic [63:0]   energy_in = '0;
  logic [2:0]    pulse_pin;
  logic [191:0]  snap_out;

  int n_chk = 0;
  int n_bad = 0;
  int m_acc [3];
  bit m_pul [3];
  logic [63:0] m_snap [3];
  logic [15:0] m_cfg;

  always #10 clk = ~clk;

  epulse_selector uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .thresh(thresh), .s_valid(s_valid), .s_ready(s_ready),
    .act_sum(act_sum), .app_sum(app_sum), .energy_in(energy_in),
    .pulse_pin(pulse_pin), .snap_out(snap_out)
  );

  function automatic int src_of(input logic [2:0] m);
    if (m == 3'b010) return 1;
    if (m == 3'b001 || m == 3'b011 || m == 3'b100) return 2;
    return 0;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [63:0] nsnap [3];
    @(posedge clk);
    for (int i = 0; i < 3; i++)
      nsnap[i] = (m_pul[i] && m_cfg[12+i]) ? energy_in : m_snap[i];
    for (int i = 0; i < 3; i++) begin
      int s, v, sr;
      m_pul[i] = 1'b0;
      if (s_valid) begin
        sr = src_of(m_cfg[3*i +: 3]);
        if (sr != 2) begin
          v = (sr == 1) ? int'(app_sum[16*i +: 16]) : int'(act_sum[16*i +: 16]);
          s = m_acc[i] + v;
          if (s >= int'(thresh)) begin m_pul[i] = 1'b1; m_acc[i] = s - int'(thresh); end
          else m_acc[i] = s;
        end
      end
      m_snap[i] = nsnap[i];
    end
    if (cfg_we) m_cfg = cfg_wdata;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      check({tag, " pin"}, 64'(pulse_pin[i]), 64'(m_pul[i] & ~m_cfg[9+i]));
      check({tag, " snap"}, snap_out[64*i +: 64], m_snap[i]);
    end
    check("R11 ready", 64'(s_ready), 64'd1);
  endtask

  task automatic drive(input bit we, input logic [15:0] wd, input bit v, input int maxv);
    cfg_we = we;
    cfg_wdata = wd;
    s_valid = v;
    for (int i = 0; i < 3; i++) begin
      act_sum[16*i +: 16] = 16'($urandom_range(0, maxv));
      app_sum[16*i +: 16] = 16'($urandom_range(0, maxv));
    end
    energy_in = {$urandom, $urandom};
  endtask

  task automatic run(input int n, input logic [15:0] cfgv, input bit rnd_valid, input string tag);
    drive(1'b1, cfgv, 1'b0, 100);
    step(tag);
    for (int k = 0; k < n; k++) begin
      drive(1'b0, cfgv, rnd_valid ? 1'($urandom_range(0, 1)) : 1'b1, int'(thresh));
      step(tag);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 3; i++) begin m_acc[i] = 0; m_pul[i] = 0; m_snap[i] = '0; end
    m_cfg = 16'h0E00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 pins", 64'(pulse_pin), 64'd0);
    check("R1 snap", snap_out[63:0] | snap_out[127:64] | snap_out[191:128], 64'd0);
    // R1: converters run while pins are disabled by reset value
    for (int k = 0; k < 10; k++) begin drive(1'b0, 16'h0, 1'b1, 100); step("R1/R6"); end
    // R2 R3 R4 R7 R10: modes 000, 010, 001, all enabled, latching on
    run(60, 16'h7050, 1'b0, "R2/R3/R4/R7/R10");
    // R5 R8: reserved modes with bit 15 set
    run(60, 16'h81F5, 1'b0, "R5/R8");
    // R6: disabled then re-enabled without reset
    run(20, 16'h7E12, 1'b0, "R6");
    run(30, 16'h7012, 1'b0, "R6");
    // R9: write on the same edge as a beat
    for (int k = 0; k < 40; k++) begin
      drive(1'b1, 16'($urandom_range(0, 16'hFFFF)), 1'b1, 100);
      step("R9");
    end
    // R11: gaps in the sample stream
    thresh = 20'd37;
    run(60, 16'h7010, 1'b1, "R11/R10");
    // random control words mixed with gaps
    for (int k = 0; k < 300; k++) begin
      drive(1'($urandom_range(0, 7) == 0), 16'($urandom_range(0, 16'hFFFF)),
            1'($urandom_range(0, 3) != 0), int'(thresh));
      step("R2/R3/R5/R7/R9");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule